// File: doc/BRIEF.md
# Descriptor Event Status and Interrupt Gate

This block keeps the interrupt event flags for a DMA engine that fills chains of buffer descriptors. It has a receive side and a transmit side. Each side reports every finished descriptor with a one-cycle completion strobe and a flag that says whether that descriptor closed its frame. A descriptor that closes a frame sets the side's frame-done event. A descriptor in the middle of a frame sets the side's buffer-done event. A frame that fits in one buffer therefore sets only the frame-done event.

Software reads the event register through a single-cycle register port. Reading changes nothing. To acknowledge events, software writes ones to the bits it wants cleared. Writing back exactly the value it read acknowledges only the events it has seen. A separate read/write enable register selects which events drive the single level-sensitive interrupt line. That line comes from a flop, so it is glitch-free. When a hardware set and a software clear hit the same bit in the same cycle, the set wins, so no event is lost to an acknowledge.

Top module: `evt_irq_regs`

## Requirements
- R1: After reset the event register (address 0) and the enable register (address 1) both read 0, and `irq_o` is low.
- R2: A write to address 0 clears every event bit whose write-data bit is 1, at the clock edge of the write.
- R3: A write to address 0 leaves every event bit whose write-data bit is 0 unchanged. Writing back a value that was read clears only the bits set in that value.
- R4: A receive completion (`desc_done[0]`) with `desc_last[0]` low sets event bit 1 (receive buffer-done) at that clock edge.
- R5: A receive completion with `desc_last[0]` high sets event bit 0 (receive frame-done) and does not set bit 1. A one-buffer frame never raises bit 1.
- R6: Transmit completions on index 1 set event bit 2 when `desc_last[1]` is high and event bit 3 when it is low.
- R7: `irq_o` is high in the cycle after any event bit and its matching enable bit are both 1 at a clock edge. It stays high until software clears every such bit or disables it.
- R8: Reading either register has no side effect. Repeated reads return the same value and pending events stay set.
- R9: If a completion sets an event bit in the same cycle that a write of 1 clears it, the bit stays set.
- R10: The enable register at address 1 reads back the last value written to bits 3:0. An event whose enable bit is 0 is still recorded and readable, but does not drive `irq_o`.
- R11: Addresses 2 and 3, and bits 31:4 of both registers, read as 0. Writes to addresses 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, single cycle |
| reg_addr | input | 2 | Register address: 0 = events, 1 = enables |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| desc_done | input | 2 | Descriptor completion strobes: bit 0 = receive, bit 1 = transmit |
| desc_last | input | 2 | Per side: the completed descriptor ends its frame |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The bench targets a completion that arrives in the same cycle as a write of ones. A design that lets the clear win would drop that event and read back zero. Write-back acknowledges come with a value that covers only part of the pending set; a design that clears on zero bits, or on read, would lose the other events. One-buffer frames are mixed with multi-buffer frames, because a decoder that ignores the last flag would raise the buffer-done bit on every descriptor. Disabled events are checked to make sure they are still recorded, and the interrupt is timed one cycle behind the register, so a design that is combinational or holds the line too long is reported.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
    // Register addresses
    localparam int unsigned ADR_EVENTS  = 0;
    localparam int unsigned ADR_ENABLES = 1;

    // Event bit layout per side: frame-done at even, buffer-done at odd
    function automatic int unsigned frame_pos(input int unsigned side);
        return 2 * side;
    endfunction

    function automatic int unsigned chunk_pos(input int unsigned side);
        return 2 * side + 1;
    endfunction
endpackage

// File: rtl/evt_decode.sv
module evt_decode #(
    parameter int unsigned N_SIDE = 2,
    localparam int unsigned EVW   = 2 * N_SIDE
) (
    input  logic [N_SIDE-1:0] done_i,
    input  logic [N_SIDE-1:0] last_i,
    output logic [EVW-1:0]    set_o
);
    import evt_irq_pkg::*;

    for (genvar s = 0; s < N_SIDE; s++) begin : g_side
        always_comb begin
            set_o[frame_pos(s)] = done_i[s] &  last_i[s];
            set_o[chunk_pos(s)] = done_i[s] & ~last_i[s];
        end
    end
endmodule

// File: rtl/evt_w1c_reg.sv
module evt_w1c_reg #(
    parameter int unsigned EVW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [EVW-1:0] clr_i,
    input  logic [EVW-1:0] set_i,
    output logic [EVW-1:0] evt_o
);
    typedef struct packed {
        logic [EVW-1:0] evt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        // hardware set is applied after the clear so it wins
        st_d.evt = (st_q.evt & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign evt_o = st_q.evt;

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((evt_o & $past(set_i)) == $past(set_i)));

    // R2
    clear_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i)) |=> ((evt_o & $past(clr_i & ~set_i)) == '0));

    // R3
    untouched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (((evt_o ^ $past(evt_o)) & ~$past(set_i | clr_i)) == '0));
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
    parameter int unsigned EVW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_we_i,
    input  logic [EVW-1:0] en_wdata_i,
    input  logic [EVW-1:0] evt_i,
    output logic [EVW-1:0] en_o,
    output logic           irq_o
);
    typedef struct packed {
        logic [EVW-1:0] en;
        logic           irq;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(evt_i & st_q.en);
        if (en_we_i) st_d.en = en_wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o  = st_q.en;
    assign irq_o = st_q.irq;

    // R10
    en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_we_i |=> (en_o == $past(en_wdata_i)));

    // R7
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && (|(evt_i & en_o)) && !en_we_i) |=> irq_o);
endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs #(
    parameter int unsigned N_SIDE = 2,
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_SIDE-1:0] desc_done,
    input  logic [N_SIDE-1:0] desc_last,
    output logic              irq_o
);
    import evt_irq_pkg::*;

    localparam int unsigned EVW = 2 * N_SIDE;
    localparam logic [ADDR_W-1:0] A_EVT = ADDR_W'(ADR_EVENTS);
    localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(ADR_ENABLES);

    logic [EVW-1:0] set_vec;
    logic [EVW-1:0] clr_vec;
    logic [EVW-1:0] evt_q;
    logic [EVW-1:0] en_q;
    logic           hit_evt, hit_en;

    assign hit_evt = reg_wr && (reg_addr == A_EVT);
    assign hit_en  = reg_wr && (reg_addr == A_EN);
    assign clr_vec = hit_evt ? reg_wdata[EVW-1:0] : '0;

    evt_decode #(.N_SIDE(N_SIDE)) u_dec (
        .done_i (desc_done),
        .last_i (desc_last),
        .set_o  (set_vec)
    );

    evt_w1c_reg #(.EVW(EVW)) u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr_vec),
        .set_i (set_vec),
        .evt_o (evt_q)
    );

    irq_gate #(.EVW(EVW)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_we_i    (hit_en),
        .en_wdata_i (reg_wdata[EVW-1:0]),
        .evt_i      (evt_q),
        .en_o       (en_q),
        .irq_o      (irq_o)
    );

    // side-effect-free read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_EVT)     reg_rdata[EVW-1:0] = evt_q;
        else if (reg_addr == A_EN) reg_rdata[EVW-1:0] = en_q;
    end

    // R7
    irq_off_after_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_en && (reg_wdata[EVW-1:0] == '0)) |=> ##1 !irq_o);

    // R5
    single_buf_no_chunk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_done[0] && desc_last[0] && !evt_q[chunk_pos(0)]) |=> !evt_q[chunk_pos(0)]);
endmodule

// File: tb/sim_evt_irq_regs.sv
`timescale 1ns/1ps
module sim_evt_irq_regs;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [1:0]  desc_done;
    logic [1:0]  desc_last;
    logic        irq_o;

    int checks = 0;
    int bad    = 0;
    bit finished = 1'b0;

    logic [3:0] m_evt, m_en;
    logic       m_irq;

    always #4 clk = ~clk;

    evt_irq_regs u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .desc_done(desc_done), .desc_last(desc_last), .irq_o(irq_o)
    );

    function automatic logic [3:0] sets_of(input logic [1:0] dn, input logic [1:0] ls);
        logic [3:0] v;
        v[0] = dn[0] & ls[0];  v[1] = dn[0] & ~ls[0];
        v[2] = dn[1] & ls[1];  v[3] = dn[1] & ~ls[1];
        return v;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [1:0] a);
        if (a == 2'd0) return {28'b0, m_evt};
        if (a == 2'd1) return {28'b0, m_en};
        return 32'b0;
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock cycle: drive, check read, clock, update model, check irq
    task automatic cyc(input logic wr, input logic [1:0] a, input logic [31:0] wd,
                       input logic [1:0] dn, input logic [1:0] ls, input string tag);
        logic nirq;
        reg_wr = wr; reg_addr = a; reg_wdata = wd; desc_done = dn; desc_last = ls;
        #1;
        check(reg_rdata, exp_rd(a), {tag, " rdata"});
        @(posedge clk);
        nirq = |(m_evt & m_en);
        if (wr && a == 2'd0) m_evt = m_evt & ~wd[3:0];
        if (wr && a == 2'd1) m_en  = wd[3:0];
        m_evt = m_evt | sets_of(dn, ls);
        m_irq = nirq;
        @(negedge clk);
        check({31'b0, irq_o}, {31'b0, m_irq}, {tag, " irq"});
    endtask

    task automatic peek(input logic [1:0] a, input logic [31:0] exp, input string tag);
        reg_wr = 1'b0; reg_addr = a; desc_done = 2'b0;
        #1;
        check(reg_rdata, exp, tag);
    endtask

    initial begin
        #1600000;
        if (!finished) begin
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        void'($urandom(32'd1234));
        rst_n = 1'b0; reg_wr = 0; reg_addr = 0; reg_wdata = 0; desc_done = 0; desc_last = 0;
        m_evt = 0; m_en = 0; m_irq = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        peek(2'd0, 32'h0, "R1 events");
        peek(2'd1, 32'h0, "R1 enables");
        check({31'b0, irq_o}, 32'h0, "R1 irq");

        // R4 mid-frame receive descriptor
        cyc(0, 0, 0, 2'b01, 2'b00, "R4");
        peek(2'd0, 32'h2, "R4 rx chunk bit");
        // R5 frame end
        cyc(0, 0, 0, 2'b01, 2'b01, "R5");
        peek(2'd0, 32'h3, "R5 rx frame bit");
        cyc(1, 0, 32'hF, 2'b00, 2'b00, "R2 clear all");
        peek(2'd0, 32'h0, "R2 all cleared");
        cyc(0, 0, 0, 2'b01, 2'b01, "R5 one-buffer frame");
        peek(2'd0, 32'h1, "R5 only frame bit");

        // R6 transmit side
        cyc(0, 0, 0, 2'b10, 2'b00, "R6 tx chunk");
        cyc(0, 0, 0, 2'b10, 2'b10, "R6 tx frame");
        peek(2'd0, 32'hD, "R6 tx bits");

        // R8 repeated reads change nothing
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 2'b00, 2'b00, "R8 read");
        peek(2'd0, 32'hD, "R8 still pending");

        // R3 write-back of a partial view
        cyc(1, 0, 32'h4, 2'b00, 2'b00, "R3 ack bit2");
        peek(2'd0, 32'h9, "R3 others kept");

        // R9 set collides with clear
        cyc(1, 0, 32'hF, 2'b01, 2'b01, "R9 collide");
        peek(2'd0, 32'h1, "R9 set wins");

        // R10 disabled event recorded, no irq
        cyc(0, 0, 0, 2'b10, 2'b00, "R10 tx chunk");
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 2'b00, 2'b00, "R10 masked");
        check({31'b0, irq_o}, 32'h0, "R10 irq low while disabled");
        peek(2'd0, 32'h9, "R10 still recorded");
        cyc(1, 1, 32'hFFFF_FFF8, 2'b00, 2'b00, "R10 enable bit3");
        peek(2'd1, 32'h8, "R10 enable readback");
        check({31'b0, irq_o}, 32'h0, "R7 irq one cycle late");
        cyc(0, 0, 0, 2'b00, 2'b00, "R7 rise");
        check({31'b0, irq_o}, 32'h1, "R7 irq high");
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, 2'b00, 2'b00, "R7 hold");
        check({31'b0, irq_o}, 32'h1, "R7 irq still high");
        cyc(1, 0, 32'h8, 2'b00, 2'b00, "R7 ack");
        cyc(0, 0, 0, 2'b00, 2'b00, "R7 drop");
        check({31'b0, irq_o}, 32'h0, "R7 irq dropped");

        // R11 unmapped addresses
        cyc(1, 2, 32'hFFFF_FFFF, 2'b00, 2'b00, "R11 write a2");
        cyc(1, 3, 32'hFFFF_FFFF, 2'b00, 2'b00, "R11 write a3");
        peek(2'd2, 32'h0, "R11 read a2");
        peek(2'd0, 32'h1, "R11 events intact");
        peek(2'd1, 32'h8, "R11 enables intact");

        // random traffic checked against the model
        for (int i = 0; i < 3000; i++) begin
            logic       w;
            logic [1:0] a;
            rv = $urandom();
            w  = ($urandom() % 3) == 0;
            a  = 2'($urandom() % 4);
            if (w && a == 2'd0 && rv[0]) rv = exp_rd(2'd0); // R3 write-back
            cyc(w, a, rv, 2'($urandom()), 2'($urandom()), "R2 R3 R9 R7 random");
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule